// File: doc/BRIEF.md
# Single-Channel Word Copy Engine

This block copies 32-bit words from a source address window to a destination address window, one word per clock whenever the memory side accepts. Software programs it through a small write-only configuration port: a control word, a size word (total words and chunk length), a start address and an address mask for each side, and an interrupt mask with one bit per channel in the system. After each word, each address steps by four bytes, but only the bits covered by its mask change. Either side can therefore cycle through a small ring buffer while the other side walks a linear region.

The channel runs in one of two modes. In the software mode it runs as soon as it is enabled. In the handshake mode a peripheral paces it with a request input. The peripheral can cut a descriptor short with a next-descriptor input, and it receives a pulse each time a full chunk has been moved. When descriptor use is enabled, the start addresses and sizes come from a parallel descriptor port rather than from the registers. A stop bit aborts the channel and flags an error, which can raise an interrupt.

The memory side has a read lane and a write lane, each with valid/ready. Both lanes present their valid in the same cycle. The read data is forwarded unchanged as the write data. A word counts as moved only in a cycle where both readies are high. While either ready is low, both valids stay high and both addresses stay stable. Read data must be returned in the cycle the read lane is ready, and a read may be repeated, so reads must have no side effects.

Top module: `dmach_engine`

## Requirements
- R1: After reset, the enable, busy, done, error and interrupt outputs are 0, the interrupt source is 0, the total-size readback is 0, both memory valids are low, the chunk acknowledge is low, and both address masks are 0xFFFFFFFC.
- R2: The configuration port selects registers by `cfg_sel`: 0 control, 1 size, 2 source, 3 source mask, 4 destination, 5 destination mask, 6 interrupt mask. In the control word, bit 0 is enable, bit 1 is handshake mode, bit 2 is descriptor use, bit 3 is size write-back, bit 4 is stop and bit 5 is error-interrupt enable. In the size word, bits 11:0 hold the total and bits 23:16 hold the chunk length. A control write updates only these six bits, and the busy, done and error flags keep their values across it. A control write that sets enable from 0 starts a transfer.
- R3: A control write that clears enable cancels the transfer. Busy drops in that same edge, no further memory beat is issued, and done is left unchanged.
- R4: On the first active cycle the channel clears done, error, the interrupt flag and the interrupt source, and sets busy. It loads the addresses, total and chunk length, taking them from the descriptor port when descriptor use is set and from the registers otherwise. The first word can move in that same cycle.
- R5: In any cycle where the channel is active and no configuration write is taking place, both memory valids are high. The write address is the destination, and the write data equals the read data. A word moves in each such cycle in which both readies are high.
- R6: After each word, each address becomes (a AND NOT m) OR ((a + 4) AND m), where m is that side's mask.
- R7: In handshake mode, a cycle with the request low does nothing: no beat, no start, and no loss of position.
- R8: The chunk acknowledge is high for one cycle, in the cycle right after a beat that brings the words moved so far to a multiple of the chunk length. A chunk length of 0 counts as 1.
- R9: The next-descriptor input acts only in handshake mode with descriptor use set, and only while the request is high. If it is high on the first active cycle, the descriptor is skipped with no beat. If it is high in a cycle where a word moves, the transfer ends after that word. In both cases the transfer ends with done set and no error.
- R10: A stop bit seen while the channel is enabled clears enable and busy and sets error. The interrupt flag is raised, and the channel's one-hot bit is written into the interrupt source, only when error-interrupt enable and this channel's interrupt-mask bit are both set.
- R11: The transfer ends normally once the words moved reach or exceed the total. Enable and busy then clear and done is set. A total of 0 still moves one word.
- R12: When size write-back and descriptor use are both set, ending a transfer stores the remaining count into the total-size field. The remaining count is the total minus the words moved, floored at 0.
- R13: While a beat is held back by a low ready, both valids stay high and the addresses stay stable until the beat completes. A configuration write stalls the engine for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Configuration write data |
| desc_src_i | input | 32 | Descriptor source address |
| desc_dst_i | input | 32 | Descriptor destination address |
| desc_total_i | input | 12 | Descriptor total words |
| desc_chunk_i | input | 8 | Descriptor chunk length |
| hs_req_i | input | 1 | Peripheral request (handshake mode) |
| hs_next_i | input | 1 | Peripheral next-descriptor request |
| hs_ack_o | output | 1 | Chunk acknowledge pulse |
| mrd_valid_o | output | 1 | Read lane valid |
| mrd_ready_i | input | 1 | Read lane ready, data valid |
| mrd_addr_o | output | 32 | Read address |
| mrd_data_i | input | 32 | Read data |
| mwr_valid_o | output | 1 | Write lane valid |
| mwr_ready_i | input | 1 | Write lane ready |
| mwr_addr_o | output | 32 | Write address |
| mwr_data_o | output | 32 | Write data |
| enable_o | output | 1 | Control enable bit |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last transfer completed |
| err_o | output | 1 | Last transfer stopped |
| err_irq_o | output | 1 | Error interrupt |
| irq_src_o | output | 4 | Interrupt source, one bit per channel |
| tot_sz_o | output | 12 | Total-size field readback |

## Verification
The hardest conditions to reach are the two early exits: a next-descriptor request on the very first active cycle, and one that lands exactly on a chosen word. The bench reaches the first by raising the request together with next-descriptor before enabling. It reaches the second by counting the beats it observes and raising next-descriptor in the gap between two clock edges. A stop can only take effect while the channel is still enabled, so the bench holds the write lane not ready. This freezes the channel in its busy state, and the stop bit is then written with enable kept set. Back-pressure is produced by a fixed, irregular ready pattern. The bench watches every held beat for stable addresses.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_SIZE = 3'd1,
    SEL_SRC  = 3'd2,
    SEL_SRCM = 3'd3,
    SEL_DST  = 3'd4,
    SEL_DSTM = 3'd5,
    SEL_IMSK = 3'd6
  } cfg_sel_e;

  localparam int CTRL_W = 6;
  localparam int B_EN   = 0;
  localparam int B_HS   = 1;
  localparam int B_DESC = 2;
  localparam int B_WB   = 3;
  localparam int B_STOP = 4;
  localparam int B_EIE  = 5;
  localparam int CHUNK_LSB = 16;
endpackage

// File: rtl/dmach_wrap_inc.sv
module dmach_wrap_inc #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  logic [AW-1:0] sum;
  assign sum = addr + STEP_V;
  assign nxt = (addr & ~mask) | (sum & mask);
endmodule

// File: rtl/dmach_pace.sv
module dmach_pace #(
  parameter int CK_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic [CK_W-1:0] chunk,
  input  logic            beat,
  output logic            ack_o
);
  logic [CK_W-1:0] cnt_q;
  logic [CK_W-1:0] limit;
  logic [CK_W-1:0] base;
  logic [CK_W:0]   nxt;

  assign limit = (chunk == '0) ? CK_W'(1) : chunk;
  assign base  = clear ? '0 : cnt_q;
  assign nxt   = {1'b0, base} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ack_o <= 1'b0;
    end else begin
      ack_o <= 1'b0;
      if (beat) begin
        if (nxt >= {1'b0, limit}) begin
          cnt_q <= '0;
          ack_o <= 1'b1;
        end else begin
          cnt_q <= nxt[CK_W-1:0];
        end
      end else if (clear) begin
        cnt_q <= '0;
      end
    end
  end

  // R8: an acknowledge always follows a completed beat
  p_ack_after_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(beat));
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
  import dmach_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SZ_W  = 12,
  parameter int CK_W  = 8,
  parameter int NCH   = 4,
  parameter int CH_ID = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_sel,
  input  logic [31:0]     cfg_wdata,
  input  logic [AW-1:0]   desc_src_i,
  input  logic [AW-1:0]   desc_dst_i,
  input  logic [SZ_W-1:0] desc_total_i,
  input  logic [CK_W-1:0] desc_chunk_i,
  input  logic            hs_req_i,
  input  logic            hs_next_i,
  output logic            hs_ack_o,
  output logic            mrd_valid_o,
  input  logic            mrd_ready_i,
  output logic [AW-1:0]   mrd_addr_o,
  input  logic [31:0]     mrd_data_i,
  output logic            mwr_valid_o,
  input  logic            mwr_ready_i,
  output logic [AW-1:0]   mwr_addr_o,
  output logic [31:0]     mwr_data_o,
  output logic            enable_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            err_irq_o,
  output logic [NCH-1:0]  irq_src_o,
  output logic [SZ_W-1:0] tot_sz_o
);
  localparam logic [AW-1:0]  MASK_RST = {{(AW-2){1'b1}}, 2'b00};
  localparam logic [NCH-1:0] CH_BIT   = {{(NCH-1){1'b0}}, 1'b1} << CH_ID;

  logic [CTRL_W-1:0] ctrl_q;
  logic [SZ_W-1:0]   tot_q, wtot_q;
  logic [CK_W-1:0]   chk_q, wchk_q;
  logic [AW-1:0]     srcr_q, srcm_q, dstr_q, dstm_q, src_q, dst_q;
  logic [NCH-1:0]    imsk_q, isrc_q;
  logic              busy_q, done_q, err_q, ierr_q;
  logic [SZ_W:0]     cnt_q;

  logic            en, hs, dsc, run, stop_now, go, first, nd_on, skip;
  logic            mvalid, beat, fin_nd, fin_full, finish;
  logic [AW-1:0]   ld_src, ld_dst, cur_src, cur_dst, src_nxt, dst_nxt;
  logic [SZ_W-1:0] ld_tot, cur_tot, remain;
  logic [CK_W-1:0] ld_chk, cur_chk;
  logic [SZ_W:0]   cnt_nx, tot_ext;

  assign en  = ctrl_q[B_EN];
  assign hs  = ctrl_q[B_HS];
  assign dsc = ctrl_q[B_DESC];

  assign run      = en && !cfg_we;
  assign stop_now = run && ctrl_q[B_STOP];
  assign go       = run && !ctrl_q[B_STOP] && (!hs || hs_req_i);
  assign first    = go && !busy_q;
  assign nd_on    = hs && dsc && hs_next_i;
  assign skip     = first && nd_on;

  assign ld_src = dsc ? desc_src_i   : srcr_q;
  assign ld_dst = dsc ? desc_dst_i   : dstr_q;
  assign ld_tot = dsc ? desc_total_i : tot_q;
  assign ld_chk = dsc ? desc_chunk_i : chk_q;

  assign cur_src = busy_q ? src_q  : ld_src;
  assign cur_dst = busy_q ? dst_q  : ld_dst;
  assign cur_tot = busy_q ? wtot_q : ld_tot;
  assign cur_chk = busy_q ? wchk_q : ld_chk;

  assign mvalid   = go && !skip;
  assign beat     = mvalid && mrd_ready_i && mwr_ready_i;
  assign cnt_nx   = (busy_q ? cnt_q : '0) + 1'b1;
  assign tot_ext  = {1'b0, cur_tot};
  assign fin_nd   = beat && nd_on;
  assign fin_full = beat && (cnt_nx >= tot_ext);
  assign finish   = skip || fin_nd || fin_full;
  assign remain   = skip ? cur_tot :
                    (tot_ext > cnt_nx) ? SZ_W'(tot_ext - cnt_nx) : '0;

  dmach_wrap_inc #(.AW(AW), .STEP(4)) u_src_inc (
    .addr(cur_src), .mask(srcm_q), .nxt(src_nxt));
  dmach_wrap_inc #(.AW(AW), .STEP(4)) u_dst_inc (
    .addr(cur_dst), .mask(dstm_q), .nxt(dst_nxt));

  dmach_pace #(.CK_W(CK_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .clear(first), .chunk(cur_chk),
    .beat(beat), .ack_o(hs_ack_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;  tot_q  <= '0;  chk_q  <= '0;
      srcr_q <= '0;  dstr_q <= '0;  srcm_q <= MASK_RST; dstm_q <= MASK_RST;
      imsk_q <= '0;  isrc_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; ierr_q <= 1'b0;
      src_q  <= '0;  dst_q  <= '0;  wtot_q <= '0;  wchk_q <= '0; cnt_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_CTRL: begin
          ctrl_q <= cfg_wdata[CTRL_W-1:0];
          if (!cfg_wdata[B_EN]) busy_q <= 1'b0;
        end
        SEL_SIZE: begin
          tot_q <= cfg_wdata[SZ_W-1:0];
          chk_q <= cfg_wdata[CHUNK_LSB +: CK_W];
        end
        SEL_SRC:  srcr_q <= cfg_wdata[AW-1:0];
        SEL_SRCM: srcm_q <= cfg_wdata[AW-1:0];
        SEL_DST:  dstr_q <= cfg_wdata[AW-1:0];
        SEL_DSTM: dstm_q <= cfg_wdata[AW-1:0];
        SEL_IMSK: imsk_q <= cfg_wdata[NCH-1:0];
        default: ;
      endcase
    end else if (stop_now) begin
      ctrl_q[B_EN] <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b1;
      if (ctrl_q[B_EIE] && (imsk_q & CH_BIT) != '0) begin
        ierr_q <= 1'b1;
        isrc_q <= CH_BIT;
      end
    end else begin
      if (first) begin
        done_q <= 1'b0; err_q <= 1'b0; ierr_q <= 1'b0; isrc_q <= '0;
        busy_q <= 1'b1;
        src_q  <= ld_src; dst_q <= ld_dst;
        wtot_q <= ld_tot; wchk_q <= ld_chk; cnt_q <= '0;
      end
      if (beat) begin
        src_q <= src_nxt;
        dst_q <= dst_nxt;
        cnt_q <= cnt_nx;
      end
      if (finish) begin
        ctrl_q[B_EN] <= 1'b0;
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (ctrl_q[B_WB] && dsc) tot_q <= remain;
      end
    end
  end

  assign mrd_valid_o = mvalid;
  assign mwr_valid_o = mvalid;
  assign mrd_addr_o  = cur_src;
  assign mwr_addr_o  = cur_dst;
  assign mwr_data_o  = mrd_data_i;
  assign enable_o    = en;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign err_irq_o   = ierr_q;
  assign irq_src_o   = isrc_q;
  assign tot_sz_o    = tot_q;

  // R3: busy never outlives the enable bit
  p_busy_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> en);
  // R7: handshake mode moves nothing without a request
  p_req_gates_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid_o && hs) |-> hs_req_i);
  // R10: a newly set error leaves the channel disabled and idle
  p_err_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (!en && !busy_q));
  // R10: the interrupt needs both the enable bit and the mask bit
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ierr_q) |-> $past(ctrl_q[B_EIE] && ((imsk_q & CH_BIT) != '0)));
  // R13: a held beat keeps its read address
  p_hold_addr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid_o && !(mrd_ready_i && mwr_ready_i)) |=>
      (!mrd_valid_o || $stable(mrd_addr_o)));
endmodule

// File: tb/sim_dmach_engine.sv
module sim_dmach_engine;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] desc_src = '0, desc_dst = '0;
  logic [11:0] desc_total = '0;
  logic [7:0]  desc_chunk = '0;
  logic        hs_req = 1'b0, hs_next = 1'b0;
  logic        hs_ack, mrd_valid, mwr_valid, rd_rdy, wr_rdy;
  logic [31:0] mrd_addr, mwr_addr, mwr_data, mrd_data;
  logic        enable, busy, done, err, irq;
  logic [3:0]  isrc;
  logic [11:0] tot_sz;

  int n_chk = 0, n_bad = 0, nbeats = 0, nacks = 0, cyc = 0;
  logic bp_mode = 1'b0, hold_wr = 1'b0, finished = 1'b0;
  logic [31:0] log_src [0:511];
  logic [31:0] log_dst [0:511];
  logic [31:0] log_wd  [0:511];
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  always #(CLK_T/2) clk = ~clk;

  assign mrd_data = 32'h5A00_0000 ^ mrd_addr;

  dmach_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .desc_src_i(desc_src), .desc_dst_i(desc_dst), .desc_total_i(desc_total),
    .desc_chunk_i(desc_chunk), .hs_req_i(hs_req), .hs_next_i(hs_next), .hs_ack_o(hs_ack),
    .mrd_valid_o(mrd_valid), .mrd_ready_i(rd_rdy), .mrd_addr_o(mrd_addr), .mrd_data_i(mrd_data),
    .mwr_valid_o(mwr_valid), .mwr_ready_i(wr_rdy), .mwr_addr_o(mwr_addr), .mwr_data_o(mwr_data),
    .enable_o(enable), .busy_o(busy), .done_o(done), .err_o(err), .err_irq_o(irq),
    .irq_src_o(isrc), .tot_sz_o(tot_sz));

  // ready pattern, driven away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (bp_mode) begin
      rd_rdy <= (cyc % 3) != 1;
      wr_rdy <= (cyc % 5) != 2;
    end else begin
      rd_rdy <= 1'b1;
      wr_rdy <= !hold_wr;
    end
  end

  // beat log, acknowledge count and held-beat address watch (R13)
  always @(posedge clk) begin
    if (rst_n) begin
      if (hs_ack) nacks <= nacks + 1;
      if (prev_stall && mrd_valid) begin
        n_chk = n_chk + 1;
        if (mrd_addr !== prev_addr) begin
          n_bad = n_bad + 1;
          $display("FAIL R13 held address moved: got %h exp %h", mrd_addr, prev_addr);
        end
      end
      prev_stall <= mrd_valid && !(rd_rdy && wr_rdy);
      prev_addr  <= mrd_addr;
      if (mrd_valid && mwr_valid && rd_rdy && wr_rdy) begin
        log_src[nbeats] <= mrd_addr;
        log_dst[nbeats] <= mwr_addr;
        log_wd[nbeats]  <= mwr_data;
        nbeats <= nbeats + 1;
      end
    end
  end

  function automatic logic [31:0] winc(input logic [31:0] a, input logic [31:0] m);
    return (a & ~m) | ((a + 32'd4) & m);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 400 && enable; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_seq(input string tag, input int base, input int n,
                         input logic [31:0] s0, input logic [31:0] sm,
                         input logic [31:0] d0, input logic [31:0] dm);
    logic [31:0] s, d;
    s = s0; d = d0;
    for (int k = 0; k < n; k++) begin
      chk({tag, " src"}, log_src[base+k], s);
      chk({tag, " dst"}, log_dst[base+k], d);
      chk({tag, " data"}, log_wd[base+k], 32'h5A00_0000 ^ s);
      s = winc(s, sm); d = winc(d, dm);
    end
  endtask

  task automatic t_reset();
    chk("R1 enable", {31'd0, enable}, 0);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 err", {31'd0, err}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 isrc", {28'd0, isrc}, 0);
    chk("R1 tot", {20'd0, tot_sz}, 0);
    chk("R1 valid", {30'd0, mrd_valid, mwr_valid}, 0);
    chk("R1 ack", {31'd0, hs_ack}, 0);
  endtask

  task automatic t_linear();
    int b, a;
    b = nbeats; a = nacks;
    cfg(3'd2, 32'h0000_0000);
    cfg(3'd4, 32'h0000_0080);
    cfg(3'd1, 32'h0000_0005);
    cfg(3'd0, 32'h1);
    wait_end();
    chk("R5 R11 beats", nbeats - b, 5);
    chk_seq("R6 R1 linear", b, 5, 32'h0, 32'hFFFF_FFFC, 32'h80, 32'hFFFF_FFFC);
    chk("R11 done", {31'd0, done}, 1);
    chk("R11 busy", {31'd0, busy}, 0);
    chk("R8 chunk0 acks", nacks - a, 5);
    cfg(3'd0, 32'h0000_0022);
    chk("R2 done kept", {31'd0, done}, 1);
    chk("R2 no start", nbeats - b, 5);
  endtask

  task automatic t_wrap();
    int b;
    b = nbeats;
    cfg(3'd2, 32'h0000_0010);
    cfg(3'd3, 32'h0000_000C);
    cfg(3'd4, 32'h0000_00A0);
    cfg(3'd1, 32'h0000_0006);
    cfg(3'd0, 32'h1);
    wait_end();
    chk("R6 beats", nbeats - b, 6);
    chk_seq("R6 wrap", b, 6, 32'h10, 32'h0C, 32'hA0, 32'hFFFF_FFFC);
    cfg(3'd3, 32'hFFFF_FFFC);
  endtask

  task automatic t_backpressure();
    int b;
    b = nbeats;
    bp_mode = 1'b1;
    cfg(3'd2, 32'h0000_0040);
    cfg(3'd4, 32'h0000_0090);
    cfg(3'd1, 32'h0000_0006);
    cfg(3'd0, 32'h1);
    wait_end();
    bp_mode = 1'b0;
    chk("R13 beats", nbeats - b, 6);
    chk_seq("R13 order", b, 6, 32'h40, 32'hFFFF_FFFC, 32'h90, 32'hFFFF_FFFC);
  endtask

  task automatic t_handshake();
    int b, a, m;
    b = nbeats; a = nacks;
    hs_req = 1'b0;
    cfg(3'd2, 32'h0000_0004);
    cfg(3'd4, 32'h0000_00C4);
    cfg(3'd1, 32'h0003_0007);
    cfg(3'd0, 32'h3);
    repeat (4) @(negedge clk);
    chk("R7 idle beats", nbeats - b, 0);
    chk("R7 not busy", {31'd0, busy}, 0);
    hs_req = 1'b1;
    while (nbeats - b < 2) @(negedge clk);
    hs_req = 1'b0;
    m = nbeats - b;
    repeat (4) @(negedge clk);
    chk("R7 paused beats", nbeats - b, m);
    chk("R7 paused busy", {31'd0, busy}, 1);
    hs_req = 1'b1;
    wait_end();
    hs_req = 1'b0;
    chk("R7 beats", nbeats - b, 7);
    chk_seq("R7 order", b, 7, 32'h04, 32'hFFFF_FFFC, 32'hC4, 32'hFFFF_FFFC);
    chk("R8 acks", nacks - a, 2);
  endtask

  task automatic t_skip();
    int b;
    b = nbeats;
    desc_src = 32'h0000_0030; desc_dst = 32'h0000_00D0;
    desc_total = 12'd9; desc_chunk = 8'd0;
    hs_req = 1'b1; hs_next = 1'b1;
    cfg(3'd0, 32'hF);
    wait_end();
    hs_next = 1'b0; hs_req = 1'b0;
    chk("R9 skip beats", nbeats - b, 0);
    chk("R9 skip done", {31'd0, done}, 1);
    chk("R9 skip err", {31'd0, err}, 0);
    chk("R12 skip remain", {20'd0, tot_sz}, 9);
  endtask

  task automatic t_next_after();
    int b;
    b = nbeats;
    desc_src = 32'h0000_0020; desc_dst = 32'h0000_00C0;
    desc_total = 12'd10; desc_chunk = 8'd2;
    hs_req = 1'b1;
    cfg(3'd0, 32'hF);
    while (nbeats - b < 3) @(negedge clk);
    hs_next = 1'b1;
    wait_end();
    hs_next = 1'b0; hs_req = 1'b0;
    chk("R9 next beats", nbeats - b, 4);
    chk_seq("R4 desc order", b, 4, 32'h20, 32'hFFFF_FFFC, 32'hC0, 32'hFFFF_FFFC);
    chk("R9 next done", {31'd0, done}, 1);
    chk("R12 remain", {20'd0, tot_sz}, 6);
  endtask

  task automatic t_stop();
    hold_wr = 1'b1;
    cfg(3'd6, 32'h2);
    cfg(3'd1, 32'h0000_0014);
    cfg(3'd0, 32'h21);
    repeat (2) @(negedge clk);
    chk("R4 busy", {31'd0, busy}, 1);
    chk("R4 done cleared", {31'd0, done}, 0);
    cfg(3'd0, 32'h31);
    @(negedge clk);
    chk("R10 err", {31'd0, err}, 1);
    chk("R10 en", {31'd0, enable}, 0);
    chk("R10 busy", {31'd0, busy}, 0);
    chk("R10 irq", {31'd0, irq}, 1);
    chk("R10 isrc", {28'd0, isrc}, 32'h2);
    cfg(3'd6, 32'h0);
    cfg(3'd0, 32'h21);
    repeat (2) @(negedge clk);
    chk("R4 err cleared", {31'd0, err}, 0);
    chk("R4 irq cleared", {31'd0, irq}, 0);
    cfg(3'd0, 32'h31);
    @(negedge clk);
    chk("R10 masked err", {31'd0, err}, 1);
    chk("R10 masked irq", {31'd0, irq}, 0);
    chk("R10 masked isrc", {28'd0, isrc}, 0);
    cfg(3'd0, 32'h0);
    hold_wr = 1'b0;
  endtask

  task automatic t_cancel();
    int b;
    hold_wr = 1'b1;
    cfg(3'd0, 32'h1);
    repeat (2) @(negedge clk);
    chk("R3 busy before", {31'd0, busy}, 1);
    cfg(3'd0, 32'h0);
    chk("R3 busy", {31'd0, busy}, 0);
    chk("R3 valid", {31'd0, mrd_valid}, 0);
    chk("R3 done", {31'd0, done}, 0);
    b = nbeats;
    hold_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 no beats", nbeats - b, 0);
  endtask

  task automatic t_zero();
    int b;
    b = nbeats;
    cfg(3'd2, 32'h0000_0008);
    cfg(3'd4, 32'h0000_00E8);
    cfg(3'd1, 32'h0000_0000);
    cfg(3'd0, 32'h1);
    wait_end();
    chk("R11 zero beats", nbeats - b, 1);
    chk("R11 zero done", {31'd0, done}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_wrap();
    t_backpressure();
    t_handshake();
    t_skip();
    t_next_after();
    t_stop();
    t_cancel();
    t_zero();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule